// File: doc/BRIEF.md
# Read/Write Batching Command Scheduler

This scheduler sits in front of a DRAM command bus. Reads and writes arrive on two separate request ports. A write's address and data are parked in a deferral queue, because no requester is waiting on the result. The scheduler sends column commands in runs that all go the same way. Each change of direction costs a long dead gap on the bus, and running in batches spreads that cost over many commands.

Inside a run, consecutive commands are spaced so that each data burst has the data bus to itself. A switch of direction always waits out the full turnaround gap. A run normally keeps going while its own queue has work. It ends in three cases:

- its own queue drains while the other queue has work;
- the write queue is full and at least the minimum batch of reads has been sent;
- the oldest waiting request of the other direction passes an age limit.

The age limit keeps a lone request from waiting forever. Commands leave on a valid/ready stream.

Top module: `rw_batch_sched`

## Requirements
- R1: Two commands in the same direction are at least CMD_SPACING (4) cycles apart. With cmd_ready held high and work queued, they are exactly 4 cycles apart.
- R2: When the direction changes, at least TURN_GAP (14) idle cycles separate the last command of the old direction from the first command of the new one. When the first command of the new direction is waiting and cmd_ready is high, it issues exactly 15 cycles after the last command of the old direction.
- R3: While a run is in progress and its queue still holds requests, no command of the other direction is inserted. Example: 40 queued reads followed by 40 queued writes issue as 40 reads, then 40 writes.
- R4: When the current direction's queue empties and the other queue holds requests, the scheduler switches direction after paying the gap.
- R5: During a read run with the write queue full, the scheduler switches to writes as soon as MIN_BATCH (36) reads of that run have issued. This happens whatever the age of the reads.
- R6: When the oldest request of the waiting direction reaches AGE_LIMIT (1024) cycles of age, the current run ends after at least one command, and that request is served. A lone write facing a continuous stream of reads issues between 1024 and 1046 cycles after it is accepted.
- R7: Within each direction, commands issue in acceptance order. A write command carries the data that was accepted with its address (cmd_data). A read command carries zero on cmd_data. cmd_write is 1 for a write and 0 for a read.
- R8: Each queue holds Q_DEPTH (64) requests. The queue's ready output is low exactly while the queue is full, and requests are accepted only on valid and ready.
- R9: While cmd_valid is high and cmd_ready is low, cmd_valid stays high, and cmd_write, cmd_addr and cmd_data stay unchanged.
- R10: After reset, cmd_valid is low and both request ports are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read queue can accept a request |
| rd_addr | input | ADDR_W | Read address |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write queue can accept a request |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| cmd_valid | output | 1 | Command offered on the bus |
| cmd_ready | input | 1 | Bus takes the offered command |
| cmd_write | output | 1 | 1 for a write command, 0 for a read command |
| cmd_addr | output | ADDR_W | Command address |
| cmd_data | output | DATA_W | Write data; zero for reads |

## Verification
The assertions assume the requester leaves requests on the ports that are not ready, so that the queue overflow check only guards the internal gating.

The hold check assumes only that cmd_ready may drop at any time. It also relies on the scheduler taking no run-ending decision while a command is on offer.

The stimulus never raises a valid without waiting for the matching ready. It drives cmd_ready either constantly high or, in the random phase, randomly low about one cycle in four. This keeps the exact-timing checks confined to phases where cmd_ready is steady.

// File: rtl/sched_pkg.sv
// Shared types for the read/write batching scheduler.
package sched_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2,
        ST_TURN = 2'd3
    } sched_state_t;
endpackage

// File: rtl/sched_queue.sv
// In-order request queue with a saturating age counter per slot.
// Assumes push is only raised when not full and pop only when not empty.
// head_age is the age of the oldest entry, which is always the head.
module sched_queue #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 32,
    parameter int AGE_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic             full,
    output logic             empty,
    output logic [WIDTH-1:0] head_data,
    output logic [AGE_W-1:0] head_age
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_P = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AGE_W-1:0] age_vec [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    // Storage write; data needs no reset.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST_P) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST_P) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // One saturating age counter per slot, cleared when the slot is written.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [AGE_W-1:0] age_r;
        logic             occ_r;
        // Age tracking for slot g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                age_r <= '0;
                occ_r <= 1'b0;
            end else if (push && wr_ptr == PTR_W'(g)) begin
                age_r <= '0;
                occ_r <= 1'b1;
            end else begin
                if (pop && rd_ptr == PTR_W'(g)) occ_r <= 1'b0;
                if (occ_r && age_r != AGE_MAX) age_r <= age_r + 1'b1;
            end
        end
        assign age_vec[g] = age_r;
    end

    assign full      = (count == FULL_C);
    assign empty     = (count == '0);
    assign head_data = mem[rd_ptr];
    assign head_age  = age_vec[rd_ptr];

    AST_Q_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full); // R8
    AST_Q_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty); // R7
endmodule

// File: rtl/sched_fsm.sv
// Direction controller: picks the run direction, enforces the same-direction
// spacing and the turnaround gap, and ends runs on empty queue, full write
// queue (after the minimum batch) or aged opposite request.
// Assumes TURN_GAP >= CMD_SPACING - 1 and TURN_GAP >= 1.
module sched_fsm
    import sched_pkg::*;
#(
    parameter int MIN_BATCH   = 36,
    parameter int CMD_SPACING = 4,
    parameter int TURN_GAP    = 14,
    parameter int AGE_LIMIT   = 1024,
    parameter int AGE_W       = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_empty,
    input  logic             wr_empty,
    input  logic             wr_full,
    input  logic [AGE_W-1:0] rd_age,
    input  logic [AGE_W-1:0] wr_age,
    input  logic             cmd_ready,
    output logic             cmd_valid,
    output logic             cmd_write
);
    localparam int TW = $clog2(TURN_GAP + 1);
    localparam int BW = $clog2(MIN_BATCH + 1);
    localparam logic [TW-1:0]    GAP_V  = TW'(TURN_GAP);
    localparam logic [TW-1:0]    GAP_M1 = TW'(TURN_GAP - 1);
    localparam logic [TW-1:0]    SP_V   = TW'(CMD_SPACING - 1);
    localparam logic [BW-1:0]    MIN_V  = BW'(MIN_BATCH);
    localparam logic [AGE_W-1:0] AGE_V  = AGE_W'(AGE_LIMIT);

    sched_state_t state, nstate;
    logic          tgt_write_q, ntgt_write;
    logic          last_write_q;
    logic [TW-1:0] idle_q;
    logic [BW-1:0] batch_q;
    logic          start_batch;

    logic cur_write, in_batch, d_empty, o_empty, o_aged, space_ok, force_wr;
    logic rd_aged, wr_aged, hs;

    // Issue gating for the current run.
    always_comb begin
        cur_write = (state == ST_WR);
        in_batch  = (state == ST_RD) || (state == ST_WR);
        rd_aged   = !rd_empty && (rd_age >= AGE_V);
        wr_aged   = !wr_empty && (wr_age >= AGE_V);
        d_empty   = cur_write ? wr_empty : rd_empty;
        o_empty   = cur_write ? rd_empty : wr_empty;
        o_aged    = cur_write ? rd_aged : wr_aged;
        force_wr  = (state == ST_RD) && wr_full && (batch_q >= MIN_V);
        space_ok  = (cur_write == last_write_q) ? (idle_q >= SP_V) : (idle_q >= GAP_V);
        cmd_valid = in_batch && !d_empty && space_ok;
        cmd_write = cur_write;
        hs        = cmd_valid && cmd_ready;
    end

    // Next-state selection; runs end only when no command is on offer.
    always_comb begin
        nstate      = state;
        ntgt_write  = tgt_write_q;
        start_batch = 1'b0;
        case (state)
            ST_IDLE: begin
                if (!rd_empty || !wr_empty) begin
                    nstate      = (!wr_empty && (rd_empty || wr_full || wr_aged)) ? ST_WR : ST_RD;
                    start_batch = 1'b1;
                end
            end
            ST_RD, ST_WR: begin
                if (!cmd_valid) begin
                    if (d_empty && o_empty) begin
                        nstate = ST_IDLE;
                    end else if (!o_empty && (d_empty || (o_aged && batch_q != '0) || force_wr)) begin
                        nstate     = ST_TURN;
                        ntgt_write = !cur_write;
                    end
                end
            end
            ST_TURN: begin
                if (idle_q >= GAP_M1) begin
                    nstate      = tgt_write_q ? ST_WR : ST_RD;
                    start_batch = 1'b1;
                end
            end
            default: nstate = ST_IDLE;
        endcase
    end

    // State, idle-cycle counter and run-length counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            tgt_write_q  <= 1'b0;
            last_write_q <= 1'b0;
            idle_q       <= GAP_V;
            batch_q      <= '0;
        end else begin
            state       <= nstate;
            tgt_write_q <= ntgt_write;
            if (hs) last_write_q <= cur_write;
            if (hs)                 idle_q <= '0;
            else if (idle_q != GAP_V) idle_q <= idle_q + 1'b1;
            if (start_batch)                  batch_q <= '0;
            else if (hs && batch_q != MIN_V)  batch_q <= batch_q + 1'b1;
        end
    end

    AST_NO_FLIP_RD_WR: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_RD) |=> (state != ST_WR)); // R3
    AST_NO_FLIP_WR_RD: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_WR) |=> (state != ST_RD)); // R3
endmodule

// File: rtl/rw_batch_sched.sv
// Read/write batching scheduler top: two request queues feeding a direction
// controller that emits column commands on a valid/ready stream.
// Assumes requesters hold requests until the matching ready is high.
module rw_batch_sched #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int Q_DEPTH     = 64,
    parameter int MIN_BATCH   = 36,
    parameter int CMD_SPACING = 4,
    parameter int TURN_GAP    = 14,
    parameter int AGE_LIMIT   = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_write,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data
);
    localparam int AGE_W = $clog2(AGE_LIMIT + 1);
    localparam int WQ_W  = ADDR_W + DATA_W;
    localparam int TW    = $clog2(TURN_GAP + 1);
    localparam logic [TW-1:0] CHK_GAP = TW'(TURN_GAP);
    localparam logic [TW-1:0] CHK_SP  = TW'(CMD_SPACING - 1);

    logic              rd_full, rd_empty, wr_full, wr_empty;
    logic [ADDR_W-1:0] rd_head;
    logic [WQ_W-1:0]   wr_head;
    logic [AGE_W-1:0]  rd_age, wr_age;
    logic              rd_push, wr_push, rd_pop, wr_pop;

    assign rd_ready = !rd_full;
    assign wr_ready = !wr_full;
    assign rd_push  = rd_valid && rd_ready;
    assign wr_push  = wr_valid && wr_ready;
    assign rd_pop   = cmd_valid && cmd_ready && !cmd_write;
    assign wr_pop   = cmd_valid && cmd_ready && cmd_write;

    sched_queue #(.DEPTH(Q_DEPTH), .WIDTH(ADDR_W), .AGE_W(AGE_W)) u_rdq (
        .clk(clk), .rst_n(rst_n), .push(rd_push), .push_data(rd_addr), .pop(rd_pop),
        .full(rd_full), .empty(rd_empty), .head_data(rd_head), .head_age(rd_age)
    );

    sched_queue #(.DEPTH(Q_DEPTH), .WIDTH(WQ_W), .AGE_W(AGE_W)) u_wrq (
        .clk(clk), .rst_n(rst_n), .push(wr_push), .push_data({wr_addr, wr_data}), .pop(wr_pop),
        .full(wr_full), .empty(wr_empty), .head_data(wr_head), .head_age(wr_age)
    );

    sched_fsm #(
        .MIN_BATCH(MIN_BATCH), .CMD_SPACING(CMD_SPACING), .TURN_GAP(TURN_GAP),
        .AGE_LIMIT(AGE_LIMIT), .AGE_W(AGE_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .rd_empty(rd_empty), .wr_empty(wr_empty), .wr_full(wr_full),
        .rd_age(rd_age), .wr_age(wr_age), .cmd_ready(cmd_ready),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write)
    );

    // Command payload from the head of the active direction's queue.
    always_comb begin
        if (cmd_write) begin
            cmd_addr = wr_head[WQ_W-1:DATA_W];
            cmd_data = wr_head[DATA_W-1:0];
        end else begin
            cmd_addr = rd_head;
            cmd_data = '0;
        end
    end

    // Bus-side observer: cycles since the last issued command and its direction.
    logic          chk_seen, chk_dir;
    logic [TW-1:0] chk_since;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_seen  <= 1'b0;
            chk_dir   <= 1'b0;
            chk_since <= '0;
        end else if (cmd_valid && cmd_ready) begin
            chk_seen  <= 1'b1;
            chk_dir   <= cmd_write;
            chk_since <= '0;
        end else if (chk_since != CHK_GAP) begin
            chk_since <= chk_since + 1'b1;
        end
    end

    AST_CMD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && chk_seen && cmd_write == chk_dir) |-> (chk_since >= CHK_SP)); // R1
    AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && chk_seen && cmd_write != chk_dir) |-> (chk_since >= CHK_GAP)); // R2
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_write) && $stable(cmd_addr) && $stable(cmd_data))); // R9
endmodule

// File: tb/rw_batch_sched_tb.sv
module rw_batch_sched_tb;
    localparam int AW = 32, DW = 32, SP = 4, GAP = 14, MINB = 36, AGEL = 1024;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rd_valid = 1'b0, wr_valid = 1'b0, cmd_ready = 1'b0;
    logic [AW-1:0] rd_addr = '0, wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic rd_ready, wr_ready, cmd_valid, cmd_write;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_data;

    rw_batch_sched u_dut (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    always #10 clk = ~clk;

    int n_checks = 0, n_errs = 0, cyc = 0;
    logic [AW-1:0]    exp_rd [$];
    logic [AW+DW-1:0] exp_wr [$];
    bit dir_log [$];
    int cyc_log [$];
    bit seen = 0, last_dir = 0, prev_stall = 0, stall_dir = 0, rand_done = 0;
    int last_cyc = 0;
    logic [AW-1:0] stall_addr = '0;

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Port monitor: scoreboard, spacing/gap and hold checks, issue log.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (prev_stall)
                chk(cmd_valid && cmd_addr == stall_addr && cmd_write == stall_dir, "R9", "held command addr", cmd_addr, stall_addr);
            if (rd_valid && rd_ready) exp_rd.push_back(rd_addr);
            if (wr_valid && wr_ready) exp_wr.push_back({wr_addr, wr_data});
            if (cmd_valid && cmd_ready) begin
                if (seen) begin
                    if (cmd_write == last_dir) chk(cyc - last_cyc >= SP, "R1", "same-direction spacing", cyc - last_cyc, SP);
                    else chk(cyc - last_cyc > GAP, "R2", "turnaround spacing", cyc - last_cyc, GAP + 1);
                end
                if (cmd_write) begin
                    if (exp_wr.size() == 0) chk(0, "R7", "unexpected write", cmd_addr, 0);
                    else begin
                        chk({cmd_addr, cmd_data} == exp_wr[0], "R7", "write addr/data", cmd_addr, exp_wr[0][AW+DW-1:DW]);
                        exp_wr.delete(0);
                    end
                end else begin
                    if (exp_rd.size() == 0) chk(0, "R7", "unexpected read", cmd_addr, 0);
                    else begin
                        chk(cmd_addr == exp_rd[0] && cmd_data == '0, "R7", "read addr", cmd_addr, exp_rd[0]);
                        exp_rd.delete(0);
                    end
                end
                seen = 1; last_dir = cmd_write; last_cyc = cyc;
                dir_log.push_back(cmd_write);
                cyc_log.push_back(cyc);
            end
            prev_stall = cmd_valid && !cmd_ready;
            stall_addr = cmd_addr;
            stall_dir  = cmd_write;
        end
    end

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic push_rd(input logic [AW-1:0] a);
        rd_addr = a; rd_valid = 1'b1;
        do @(negedge clk); while (!rd_ready);
        @(posedge clk); #2;
        rd_valid = 1'b0;
    endtask

    task automatic push_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_addr = a; wr_data = d; wr_valid = 1'b1;
        do @(negedge clk); while (!wr_ready);
        @(posedge clk); #2;
        wr_valid = 1'b0;
    endtask

    task automatic drain(input int maxc);
        int k = 0;
        while ((exp_rd.size() != 0 || exp_wr.size() != 0) && k < maxc) begin tick(1); k++; end
        chk(k < maxc, "R7", "all accepted requests issued", k, maxc);
        tick(4);
    endtask

    task automatic log_clear();
        dir_log.delete();
        cyc_log.delete();
    endtask

    initial begin
        int wcyc, widx, nrd;
        void'($urandom(32'd2024));
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk(!cmd_valid, "R10", "cmd_valid after reset", cmd_valid, 0);
        chk(rd_ready && wr_ready, "R10", "ready after reset", {rd_ready, wr_ready}, 3);

        // Directed: spacing and stall hold
        log_clear();
        for (int i = 0; i < 10; i++) push_rd(32'h100 + i * 4);
        tick(3);
        chk(cmd_valid && !cmd_write && cmd_addr == 32'h100, "R9", "first read on offer during stall", cmd_addr, 32'h100);
        cmd_ready = 1'b1;
        drain(2000);
        chk(dir_log.size() == 10, "R1", "read count", dir_log.size(), 10);
        for (int i = 1; i < 10 && i < cyc_log.size(); i++)
            chk(cyc_log[i] - cyc_log[i-1] == SP, "R1", "exact spacing", cyc_log[i] - cyc_log[i-1], SP);

        // Directed: batching, no insertion, switch on empty
        cmd_ready = 1'b0;
        log_clear();
        for (int i = 0; i < 40; i++) push_rd(32'h1000 + i);
        for (int i = 0; i < 40; i++) push_wr(32'h2000 + i, ~i);
        tick(2);
        cmd_ready = 1'b1;
        drain(5000);
        chk(dir_log.size() == 80, "R3", "command count", dir_log.size(), 80);
        if (dir_log.size() == 80) begin
            for (int i = 0; i < 80; i++) chk(dir_log[i] == (i >= 40), "R3", "run direction", dir_log[i], i >= 40);
            chk(dir_log[40] == 1'b1, "R4", "switch after reads drain", dir_log[40], 1);
            chk(cyc_log[40] - cyc_log[39] == GAP + 1, "R2", "exact turnaround", cyc_log[40] - cyc_log[39], GAP + 1);
        end

        // Directed: full write queue forces switch after minimum batch
        cmd_ready = 1'b0;
        log_clear();
        for (int i = 0; i < 50; i++) push_rd(32'h3000 + i);
        for (int i = 0; i < 64; i++) push_wr(32'h4000 + i, 32'hA000 + i);
        tick(2);
        chk(!wr_ready, "R8", "write queue full at 64", wr_ready, 0);
        chk(rd_ready, "R8", "read queue not full at 50", rd_ready, 1);
        cmd_ready = 1'b1;
        drain(5000);
        chk(dir_log.size() == 114, "R5", "command count", dir_log.size(), 114);
        if (dir_log.size() == 114) begin
            nrd = 0;
            while (nrd < 114 && !dir_log[nrd]) nrd++;
            chk(nrd == MINB, "R5", "reads before forced switch", nrd, MINB);
            for (int i = MINB; i < MINB + 64; i++) chk(dir_log[i] == 1'b1, "R5", "write run", dir_log[i], 1);
            for (int i = MINB + 64; i < 114; i++) chk(dir_log[i] == 1'b0, "R4", "remaining reads", dir_log[i], 0);
            chk(cyc_log[MINB] - cyc_log[MINB-1] == GAP + 1, "R2", "forced turnaround gap", cyc_log[MINB] - cyc_log[MINB-1], GAP + 1);
        end

        // Directed: lone write aged against a continuous read stream
        log_clear();
        wcyc = 0;
        fork
            begin
                for (int i = 0; i < 300; i++) push_rd(32'h8000 + i);
            end
            begin
                tick(10);
                push_wr(32'hABC, 32'h5A5A);
                wcyc = cyc;
            end
        join
        drain(6000);
        widx = -1;
        for (int i = 0; i < dir_log.size(); i++) if (dir_log[i] && widx < 0) widx = i;
        chk(widx >= 0 && widx < dir_log.size() - 1, "R6", "write served before read stream ends", widx, 0);
        if (widx >= 0) begin
            chk(cyc_log[widx] - wcyc >= AGEL, "R6", "write wait lower bound", cyc_log[widx] - wcyc, AGEL);
            chk(cyc_log[widx] - wcyc <= AGEL + SP + GAP + 4, "R6", "write wait upper bound", cyc_log[widx] - wcyc, AGEL + SP + GAP + 4);
        end

        // Random phase with random backpressure
        log_clear();
        fork
            begin
                for (int i = 0; i < 300; i++) begin
                    int r = $urandom % 4;
                    if (r < 2) push_rd($urandom);
                    else if (r == 2) push_wr($urandom, $urandom);
                    else tick($urandom % 6);
                end
                rand_done = 1;
            end
            begin
                while (!rand_done) begin
                    tick(1);
                    cmd_ready = ($urandom % 4) != 0;
                end
            end
        join
        cmd_ready = 1'b1;
        drain(20000);
        chk(exp_rd.size() == 0 && exp_wr.size() == 0, "R7", "random phase drained", exp_rd.size() + exp_wr.size(), 0);
        chk(!cmd_valid, "R7", "no stray command", cmd_valid, 0);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog R7 actual=%0d expected=%0d", 150000, 0);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end
endmodule